// File: doc/BRIEF.md
# Asynchronous Static Memory Strobe Controller

This block sits between a synchronous host and an external asynchronous static memory with a 13-bit address and a 16-bit data word. The host presents a request for one cycle while `ready` is high. The controller latches the address and data. It then produces the chip-enable, output-enable and two write-enable strobes with intervals counted in clock cycles, so the memory sees a legal write or read. The memory is split into two halves by the top address bit. A write pulses only the write enable that belongs to the addressed half.

Writes run in one of two styles. In the write-enable style, chip enable falls first and the write enable forms the pulse. In the chip-enable style, the write enable falls first and chip enable forms the pulse. The terminating strobe rises first and the other strobe follows after the hold interval. A relaxed option adds one cycle to the setup interval and one cycle to the pulse interval. The data bus is split into `dqOut`, `dqOe` and `dqIn` so that a pad cell can build the tri-state driver. The controller turns the driver on only while a write pulse or its hold interval is in progress. Output enable stays high during every write.

Top module: `sram_wc_top`

## Requirements
- R1: After reset, `ready` is 1, `memCeN`, `memOeN` and both `memWeN` bits are 1, and `dqOe` is 0.
- R2: A write to an address with bit 12 at 0 pulls only `memWeN[0]` low. A write with bit 12 at 1 pulls only `memWeN[1]` low. The two bits are never low together.
- R3: With `modeCe`=0, a write holds `memCeN` low with both `memWeN` high for the setup count. Then `memCeN` and the selected `memWeN` are both low for the pulse count. Then `memCeN` stays low, with both `memWeN` high, for the hold count.
- R4: With `modeCe`=1, a write holds the selected `memWeN` low with `memCeN` high for the setup count. Then both are low for the pulse count. Then the selected `memWeN` stays low, with `memCeN` high, for the hold count.
- R5: `relaxed`=1 at acceptance adds one cycle to the setup count and one cycle to the pulse count of a write, and one cycle to a read. The hold count is unchanged.
- R6: `dqOe` is 1 exactly during the pulse and hold intervals of a write, `dqOut` equals the accepted write data throughout, and `memOeN` is 1 whenever `dqOe` is 1.
- R7: `memAddr` changes only on acceptance of a request and stays stable while `ready` is 0.
- R8: A request is accepted only when `ready` is 1. `ready` is 0 from the cycle after acceptance until the last setup, pulse and hold cycle (write) or read cycle has passed. Requests and mode inputs presented while `ready` is 0 have no effect on memory contents or on the current sequence.
- R9: A read (`we`=0) holds `memCeN` and `memOeN` low for the pulse count, with both `memWeN` high and `dqOe` at 0. `rdValid` is 1 for the cycle in which `ready` returns. `rdata` holds the word sampled on the last read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, taken when `ready` is 1 |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 13 | Request address; bit 12 selects the memory half |
| wdata | input | 16 | Write data |
| modeCe | input | 1 | 0 = write-enable-controlled write, 1 = chip-enable-controlled write |
| relaxed | input | 1 | Lengthens setup and pulse by one cycle each |
| ready | output | 1 | Controller idle and able to accept |
| rdata | output | 16 | Last read word |
| rdValid | output | 1 | One-cycle flag: `rdata` updated |
| memAddr | output | 13 | Memory address pins |
| memCeN | output | 1 | Memory chip enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 2 | Write enables for the low [0] and high [1] halves, active low |
| dqOut | output | 16 | Data toward the memory |
| dqOe | output | 1 | Driver enable for `dqOut` |
| dqIn | input | 16 | Data from the memory |

## Verification
A phase counter or latched mode that is wrong shows up at the strobe pins in the same cycle. Symptoms include a pulse one cycle short or long, the wrong half's write enable, or chip enable and write enable swapping roles. The bench measures each interval at every cycle of every transaction, so the transaction that carries the fault exposes it. A wrong latched address or data word appears as a wrong word in the memory model. The bench exposes it at the next read of that location and in a full comparison at the end. A busy flag that leaks lets an ignored request reach the pins within two cycles.

// File: rtl/sram_wc_pkg.sv
package sram_wc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD,
    PH_READ
  } phase_e;

  // strobes from control to datapath and pins
  typedef struct packed {
    logic       ceN;
    logic       oeN;
    logic [1:0] weN;
    logic       dqOe;
    logic       load;
    logic       capture;
  } strobe_t;

endpackage

// File: rtl/sram_wc_ctrl.sv
module sram_wc_ctrl
  import sram_wc_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1,
  parameter int LANES     = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    req,
  input  logic    we,
  input  logic    modeCe,
  input  logic    relaxed,
  input  logic    region,
  output logic    ready,
  output strobe_t strb
);

  localparam int MAX_LEN = ((SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC) + 1 > HOLD_CYC ?
                           ((SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC) + 1 : HOLD_CYC;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             ceStyle;
  logic             slowMode;
  logic             laneSel;
  logic [LANES-1:0] laneWeN;
  logic             cntDone;
  logic             accept;

  assign cntDone = (cnt == '0);
  assign ready   = (phase == PH_IDLE);
  assign accept  = ready && req;

  // one active-low write enable per memory half
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneWeN[g] = (laneSel != g[0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      ceStyle  <= 1'b0;
      slowMode <= 1'b0;
      laneSel  <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (req) begin
          ceStyle  <= modeCe;
          slowMode <= relaxed;
          laneSel  <= region;
          if (we) begin
            phase <= PH_SETUP;
            cnt   <= CNT_W'(SETUP_CYC - 1) + CNT_W'(relaxed);
          end else begin
            phase <= PH_READ;
            cnt   <= CNT_W'(PULSE_CYC - 1) + CNT_W'(relaxed);
          end
        end
        PH_SETUP: if (cntDone) begin
          phase <= PH_PULSE;
          cnt   <= CNT_W'(PULSE_CYC - 1) + CNT_W'(slowMode);
        end else cnt <= cnt - 1'b1;
        PH_PULSE: if (cntDone) begin
          phase <= PH_HOLD;
          cnt   <= CNT_W'(HOLD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        PH_HOLD, PH_READ: if (cntDone) phase <= PH_IDLE;
                          else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb         = '{ceN: 1'b1, oeN: 1'b1, weN: '1, dqOe: 1'b0, load: 1'b0, capture: 1'b0};
    strb.load    = accept;
    strb.capture = (phase == PH_READ) && cntDone;
    unique case (phase)
      PH_SETUP: if (ceStyle) strb.weN = laneWeN; else strb.ceN = 1'b0;
      PH_PULSE: begin
        strb.ceN  = 1'b0;
        strb.weN  = laneWeN;
        strb.dqOe = 1'b1;
      end
      PH_HOLD: begin
        if (ceStyle) strb.weN = laneWeN; else strb.ceN = 1'b0;
        strb.dqOe = 1'b1;
      end
      PH_READ: begin
        strb.ceN = 1'b0;
        strb.oeN = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sram_wc_dp.sv
module sram_wc_dp
  import sram_wc_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] dqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] dqOut,
  output logic [DATA_W-1:0] rdata,
  output logic              rdValid
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr <= '0;
      dqOut   <= '0;
      rdata   <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strb.load) begin
        memAddr <= addr;
        dqOut   <= wdata;
      end
      rdValid <= strb.capture;
      if (strb.capture) rdata <= dqIn;
    end
  end

endmodule

// File: rtl/sram_wc_top.sv
module sram_wc_top
  import sram_wc_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 16,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              modeCe,
  input  logic              relaxed,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rdValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic [1:0]        memWeN,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  input  logic [DATA_W-1:0] dqIn
);

  strobe_t strb;

  sram_wc_ctrl #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC), .LANES(2)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .modeCe(modeCe),
    .relaxed(relaxed), .region(addr[ADDR_W-1]), .ready(ready), .strb(strb)
  );

  sram_wc_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wdata(wdata),
    .dqIn(dqIn), .memAddr(memAddr), .dqOut(dqOut), .rdata(rdata), .rdValid(rdValid)
  );

  assign memCeN = strb.ceN;
  assign memOeN = strb.oeN;
  assign memWeN = strb.weN;
  assign dqOe   = strb.dqOe;

endmodule

// File: rtl/sram_wc_chk.sv
module sram_wc_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              req,
  input logic              ready,
  input logic              rdValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memOeN,
  input logic [1:0]        memWeN,
  input logic              dqOe
);

  // R2
  single_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memWeN));

  // R6
  drive_no_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> memOeN);

  // R6
  drive_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> (!memCeN || memWeN != 2'b11));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> $stable(memAddr));

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && req) |=> !ready);

  // R9
  read_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN == 2'b11 && !dqOe));

  // R9
  valid_on_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (ready && $past(!ready)));

endmodule

bind sram_wc_top sram_wc_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .req(req), .ready(ready), .rdValid(rdValid),
  .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN), .dqOe(dqOe)
);

// File: tb/test_sram_wc_top.sv
module test_sram_wc_top;

  localparam int CLK_PERIOD = 10;
  localparam int SETUP = 2;
  localparam int PULSE = 3;
  localparam int HOLD  = 2;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [12:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        modeCe = 1'b0;
  logic        relaxed = 1'b0;
  logic        ready, rdValid, memCeN, memOeN, dqOe;
  logic [15:0] rdata, dqOut, dqIn;
  logic [12:0] memAddr;
  logic [1:0]  memWeN;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic finished = 1'b0;

  logic [15:0] model [128];
  logic [15:0] expMem [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_wc_top #(.SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD)) i_sram_wc_top (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .modeCe(modeCe), .relaxed(relaxed), .ready(ready), .rdata(rdata),
    .rdValid(rdValid), .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN),
    .memWeN(memWeN), .dqOut(dqOut), .dqOe(dqOe), .dqIn(dqIn)
  );

  function automatic int slot(input logic [12:0] a);
    return {a[12], a[5:0]};
  endfunction

  // memory model: drives only while chip and output enable are low
  assign dqIn = (!memCeN && !memOeN) ? model[slot(memAddr)] : 16'hDEAD;

  logic        prevAct = 1'b0;
  logic [12:0] prevAddr;
  logic [15:0] prevData;
  always @(negedge clk) begin
    logic act;
    act = !memCeN && memWeN != 2'b11;
    if (prevAct && !act) model[slot(prevAddr)] = prevData;
    prevAct  = act;
    prevAddr = memAddr;
    prevData = dqOut;
  end

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [12:0] a, input logic [15:0] d,
                         input bit ce, input bit rel, input bit junk);
    int busy = 0, actN = 0, pre = 0, hold = 0, other = 0, bad = 0, guard = 0;
    bit seen = 0;
    bit r = a[12];
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; modeCe = ce; relaxed = rel;
    @(negedge clk);
    req = 0;
    while (!ready && guard < 100) begin
      bit act;
      guard++;
      busy++;
      act = !memCeN && !memWeN[r];
      if (!memWeN[!r]) other++;
      if (act) begin actN++; seen = 1; end
      if (!seen && (ce ? (memCeN && !memWeN[r]) : (!memCeN && memWeN == 2'b11))) pre++;
      if (seen && !act && dqOe && (ce ? (memCeN && !memWeN[r]) : (!memCeN && memWeN == 2'b11))) hold++;
      if ((act && !dqOe) || (dqOe && dqOut != d) || (dqOe && !memOeN) || memAddr != a) bad++;
      if (!seen && dqOe) bad++;
      if (junk) begin
        req = $urandom_range(0, 1); we = $urandom_range(0, 1);
        addr = 13'($urandom); wdata = 16'($urandom);
        modeCe = $urandom_range(0, 1); relaxed = $urandom_range(0, 1);
      end
      @(negedge clk);
    end
    req = 0;
    expMem[slot(a)] = d;
    check("R8 write busy length", busy == SETUP + PULSE + HOLD + 2*rel, busy, SETUP + PULSE + HOLD + 2*rel);
    check(rel ? "R5 relaxed pulse" : (ce ? "R4 ce-style pulse" : "R3 we-style pulse"),
          actN == PULSE + rel, actN, PULSE + rel);
    check(rel ? "R5 relaxed setup" : (ce ? "R4 ce-style setup" : "R3 we-style setup"),
          pre == SETUP + rel, pre, SETUP + rel);
    check(ce ? "R4 hold window" : "R3 hold window", hold == HOLD, hold, HOLD);
    check("R2 other lane idle", other == 0, other, 0);
    check("R6 R7 bus and address", bad == 0, bad, 0);
  endtask

  task automatic doRead(input logic [12:0] a, input bit rel);
    int busy = 0, rd = 0, guard = 0;
    @(negedge clk);
    req = 1; we = 0; addr = a; relaxed = rel; modeCe = $urandom_range(0, 1);
    @(negedge clk);
    req = 0;
    while (!ready && guard < 100) begin
      guard++;
      busy++;
      if (!memCeN && !memOeN && memWeN == 2'b11 && !dqOe) rd++;
      @(negedge clk);
    end
    check("R9 read length", busy == PULSE + rel && rd == busy, busy, PULSE + rel);
    check("R9 rdValid on return", rdValid == 1'b1, rdValid, 1);
    check("R9 read data", rdata == expMem[slot(a)], rdata, expMem[slot(a)]);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int diff;
    void'($urandom(32'd2718));
    for (int i = 0; i < 128; i++) begin model[i] = '0; expMem[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 reset ready", ready == 1'b1, ready, 1);
    check("R1 reset strobes", {memCeN, memOeN, memWeN, dqOe} == 5'b11110,
          {memCeN, memOeN, memWeN, dqOe}, 5'b11110);

    // directed: both halves at the boundary, both styles, relaxed
    doWrite(13'h0FFF, 16'hA55A, 0, 0, 0);
    doWrite(13'h1000, 16'h5AA5, 1, 0, 0);
    doWrite(13'h0000, 16'h1234, 1, 1, 0);
    doWrite(13'h1FFF, 16'hFEDC, 0, 1, 1);
    doRead(13'h0FFF, 0);
    doRead(13'h1000, 1);
    doRead(13'h0000, 0);
    doRead(13'h1FFF, 0);

    for (int n = 0; n < 200; n++) begin
      logic [12:0] a;
      a = 13'($urandom);
      if ($urandom_range(0, 2) != 0)
        doWrite(a, 16'($urandom), $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
      else
        doRead(a, $urandom_range(0, 1));
    end

    // R8: ignored requests must not have touched any location
    diff = 0;
    for (int i = 0; i < 128; i++) if (model[i] !== expMem[i]) diff++;
    check("R8 no stray writes", diff == 0, diff, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule